// File: doc/BRIEF.md
# TDM Serial Highway Timeslot Engine

This block is a full-duplex serial port for a time-division-multiplexed highway. It uses four line signals: a bit clock (the block clock), a frame sync, serial transmit data and serial receive data. It tracks the bit and timeslot position inside each frame. Timeslots carry 8-bit samples, most significant bit first. A frame is made of two equal half-frames, and each half-frame holds a programmable number of slots, from 1 to 32. A frame therefore holds up to 64 slots.

Four receive selectors and four transmit selectors each name a slot offset inside a half-frame. Each selected offset applies in both halves. The receive and transmit sets are independent. Slots that no selector names are ignored. The register side writes transmit bytes into a holding register and takes completed receive bytes from a second holding register. Each direction reports a lost or repeated sample with a one-cycle pulse.

Top module: `tdm_slot_port`

## Requirements
- R1: A rising clock edge that samples `fsync` high makes the next bit period bit 7 of slot 0. With no sync, the position advances one bit per clock and wraps to slot 0 after the last bit of the last slot of the second half-frame.
- R2: The half-frame length is H = `cfg_half_m1` + 1 slots, and the frame length is 2H slots. Frame slot s has half-frame offset s mod H. Selector i uses enable bit i and the 5-bit offset field at bits [5i+4:5i] of its offset bus. The selector names that offset in both halves. An offset of H or more never matches.
- R3: During a transmit-selected slot, `txd_oe` is 1 for all 8 bit periods. `txd` carries the slot's byte MSB first and changes only after rising edges.
- R4: During a slot that no transmit selector names, `txd_oe` is 0.
- R5: `rxd` is sampled on the falling clock edge and shifted in MSB first. The rising edge that ends the last bit of a receive-selected slot loads `rx_data` and raises `rx_valid` for one cycle. Unselected slots raise no `rx_valid` and leave `rx_data` unchanged.
- R6: `rx_overrun` pulses together with `rx_valid` when the previous byte has not been consumed. A byte is consumed when `rx_rd` is high at any rising edge after it was loaded, including the edge that loads the next byte.
- R7: `tx_wr` at a rising edge loads `tx_data` into the transmit holding register. At the start of each transmit-selected slot, the holding byte is sent. If no write occurred since the previous slot start, the previous byte is sent again and `tx_underrun` is 1 for the slot's first bit period. A write at the same edge as a slot start is used for the next slot.
- R8: Receive and transmit selections are independent. One slot may be both received and transmitted.
- R9: While `rst_n` is low, `txd_oe`, `rx_valid`, `rx_overrun`, `tx_underrun` and `rx_data` are 0, and the transmit holding byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, sampled on rising edge |
| rxd | input | 1 | Serial receive data, sampled on falling edge |
| cfg_half_m1 | input | 5 | Slots per half-frame minus one |
| rx_sel_en | input | 4 | Receive selector enables |
| rx_sel_off | input | 20 | Receive selector offsets, 5 bits each |
| tx_sel_en | input | 4 | Transmit selector enables |
| tx_sel_off | input | 20 | Transmit selector offsets, 5 bits each |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Transmit output enable, 0 means high impedance |
| tx_data | input | 8 | Byte to write into the transmit holding register |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_underrun | output | 1 | Pulse: a slot started without a fresh byte |
| rx_data | output | 8 | Receive holding register |
| rx_valid | output | 1 | Pulse: new received byte loaded |
| rx_overrun | output | 1 | Pulse: previous received byte was lost |
| rx_rd | input | 1 | Receive byte consume strobe |

## Verification
The hardest case to reach from the ports is a frame sync that arrives in the middle of a selected slot. The partly shifted byte must be dropped, and the slot-0 byte that follows must still start cleanly. Reaching the case also requires keeping the holding-register flags consistent across the break. The stimulus does this by raising sync at random bit positions in long runs. Other runs combine tiny and maximal half-frames, overlapping receive and transmit selections, out-of-range offsets, and sparse writes and reads that force underrun and overrun.

// File: rtl/tdm_slot_port.sv
module tdm_slot_port #(
  parameter int W     = 8,
  parameter int SEL_N = 4,
  parameter int OFF_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fsync,
  input  logic                   rxd,
  input  logic [OFF_W-1:0]       cfg_half_m1,
  input  logic [SEL_N-1:0]       rx_sel_en,
  input  logic [SEL_N*OFF_W-1:0] rx_sel_off,
  input  logic [SEL_N-1:0]       tx_sel_en,
  input  logic [SEL_N*OFF_W-1:0] tx_sel_off,
  output logic                   txd,
  output logic                   txd_oe,
  input  logic [W-1:0]           tx_data,
  input  logic                   tx_wr,
  output logic                   tx_underrun,
  output logic [W-1:0]           rx_data,
  output logic                   rx_valid,
  output logic                   rx_overrun,
  input  logic                   rx_rd
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] MSB = BW'(W - 1);

  logic [BW-1:0]    bit_q, bit_n;
  logic [OFF_W-1:0] hs_q, hs_n;
  logic             tx_act, rx_act, rxd_s;
  logic [W-1:0]     tx_sr, tx_hold, rx_sr, rx_word;
  logic             tx_full, rx_full;

  function automatic logic hit(input logic [SEL_N-1:0] en,
                               input logic [SEL_N*OFF_W-1:0] off,
                               input logic [OFF_W-1:0] pos);
    logic h;
    h = 1'b0;
    for (int i = 0; i < SEL_N; i++)
      if (en[i] && off[i*OFF_W +: OFF_W] == pos) h = 1'b1;
    return h;
  endfunction

  always_comb begin
    if (fsync) begin
      bit_n = MSB;
      hs_n  = '0;
    end else if (bit_q != '0) begin
      bit_n = bit_q - 1'b1;
      hs_n  = hs_q;
    end else begin
      bit_n = MSB;
      hs_n  = (hs_q >= cfg_half_m1) ? '0 : hs_q + 1'b1;
    end
  end

  wire tx_hit_n = hit(tx_sel_en, tx_sel_off, hs_n);
  wire rx_hit_n = hit(rx_sel_en, rx_sel_off, hs_n);
  wire tx_start = tx_hit_n && (bit_n == MSB);
  wire rx_done  = rx_act && (bit_q == '0);

  assign rx_word = {rx_sr[W-2:0], rxd_s};
  assign txd     = tx_sr[bit_q];
  assign txd_oe  = tx_act;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) rxd_s <= 1'b0;
    else        rxd_s <= rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q       <= '0;
      hs_q        <= '1;
      tx_act      <= 1'b0;
      rx_act      <= 1'b0;
      tx_sr       <= '0;
      tx_hold     <= '0;
      tx_full     <= 1'b0;
      tx_underrun <= 1'b0;
      rx_sr       <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_full     <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      bit_q       <= bit_n;
      hs_q        <= hs_n;
      tx_act      <= tx_hit_n;
      rx_act      <= rx_hit_n;
      tx_underrun <= 1'b0;
      if (tx_start) begin
        tx_sr       <= tx_hold;
        tx_underrun <= !tx_full;
        tx_full     <= 1'b0;
      end
      if (tx_wr) begin
        tx_hold <= tx_data;
        tx_full <= 1'b1;
      end
      if (rx_act) rx_sr <= rx_word;
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
      if (rx_done) begin
        rx_data    <= rx_word;
        rx_valid   <= 1'b1;
        rx_overrun <= rx_full && !rx_rd;
        rx_full    <= 1'b1;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk #(
  parameter int W     = 8,
  parameter int SEL_N = 4,
  parameter int OFF_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fsync,
  input logic                   txd_oe,
  input logic                   rx_valid,
  input logic                   rx_overrun,
  input logic                   tx_underrun,
  input logic [$clog2(W)-1:0]   bit_q,
  input logic [SEL_N-1:0]       tx_sel_en,
  input logic [SEL_N*OFF_W-1:0] tx_sel_off
);
  logic zero_hit;
  always_comb begin
    zero_hit = 1'b0;
    for (int i = 0; i < SEL_N; i++)
      if (tx_sel_en[i] && tx_sel_off[i*OFF_W +: OFF_W] == '0) zero_hit = 1'b1;
  end

  AST_SYNC_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (txd_oe == $past(zero_hit))); // R1
  AST_OE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_oe != $past(txd_oe)) |-> (bit_q == $clog2(W)'(W - 1))); // R3
  AST_RXV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
  AST_RXV_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(bit_q) == '0)); // R5
  AST_OVR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_valid); // R6
  AST_UND_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> (txd_oe && bit_q == $clog2(W)'(W - 1))); // R7
endmodule

bind tdm_slot_port tdm_slot_port_chk #(.W(W), .SEL_N(SEL_N), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .txd_oe(txd_oe),
  .rx_valid(rx_valid), .rx_overrun(rx_overrun), .tx_underrun(tx_underrun),
  .bit_q(bit_q), .tx_sel_en(tx_sel_en), .tx_sel_off(tx_sel_off)
);

// File: tb/tb_tdm_slot_port.sv
module tb_tdm_slot_port;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, rxd = 1'b0;
  logic [4:0]  cfg_half_m1 = 5'd3;
  logic [3:0]  rx_sel_en = '0, tx_sel_en = '0;
  logic [19:0] rx_sel_off = '0, tx_sel_off = '0;
  logic [7:0]  tx_data = '0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0;
  logic        txd, txd_oe, tx_underrun, rx_valid, rx_overrun;
  logic [7:0]  rx_data;

  tdm_slot_port dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd), .cfg_half_m1(cfg_half_m1),
    .rx_sel_en(rx_sel_en), .rx_sel_off(rx_sel_off), .tx_sel_en(tx_sel_en),
    .tx_sel_off(tx_sel_off), .txd(txd), .txd_oe(txd_oe), .tx_data(tx_data),
    .tx_wr(tx_wr), .tx_underrun(tx_underrun), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_overrun(rx_overrun), .rx_rd(rx_rd)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int H, ppos, cur_slot;
  bit primed;
  logic [7:0] rxb [0:63];
  logic [7:0] hold_m, cur_tx, last_rxd;
  bit fresh_m, full_m, exp_oe, exp_und, exp_rxv, exp_ovr, rx_also_tx;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit tsel(input int hs);
    for (int i = 0; i < 4; i++)
      if (tx_sel_en[i] && int'(tx_sel_off[i*5 +: 5]) == hs) return 1;
    return 0;
  endfunction

  function automatic bit rsel(input int hs);
    for (int i = 0; i < 4; i++)
      if (rx_sel_en[i] && int'(rx_sel_off[i*5 +: 5]) == hs) return 1;
    return 0;
  endfunction

  function automatic int hsof(input int p); return (p / 8) % H; endfunction
  function automatic int bitof(input int p); return 7 - (p % 8); endfunction

  task automatic do_reset(input int hm1, input logic [3:0] ren, input logic [19:0] roff,
                          input logic [3:0] ten, input logic [19:0] toff);
    @(negedge clk);
    rst_n = 1'b0; fsync = 0; tx_wr = 0; rx_rd = 0; rxd = 0;
    cfg_half_m1 = 5'(hm1); rx_sel_en = ren; rx_sel_off = roff;
    tx_sel_en = ten; tx_sel_off = toff;
    repeat (2) @(negedge clk);
    #1;
    chk(txd_oe == 0, "R9 txd_oe", txd_oe, 0);
    chk(rx_valid == 0 && rx_overrun == 0 && tx_underrun == 0, "R9 pulses",
        {rx_valid, rx_overrun, tx_underrun}, 0);
    chk(rx_data == 0, "R9 rx_data", rx_data, 0);
    H = hm1 + 1;
    ppos = 16 * H - 1;
    primed = 0; hold_m = 0; fresh_m = 0; full_m = 0; last_rxd = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int cycles, input int fs_per, input int wr_pct, input int rd_pct);
    int op;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      op = ppos;
      exp_rxv = 0; exp_ovr = 0; rx_also_tx = 0;
      if (primed && rsel(hsof(op)) && bitof(op) == 0) begin
        exp_rxv = 1;
        last_rxd = rxb[op / 8];
        rx_also_tx = tsel(hsof(op));
        exp_ovr = full_m && !rx_rd;
        full_m = 1;
      end else if (rx_rd) full_m = 0;
      primed = 1;
      ppos = fsync ? 0 : (ppos + 1) % (16 * H);
      if (ppos == 0)
        for (int s = 0; s < 64; s++) rxb[s] = 8'($urandom);
      exp_oe = tsel(hsof(ppos));
      exp_und = 0;
      if (exp_oe && bitof(ppos) == 7) begin
        cur_tx = hold_m;
        exp_und = !fresh_m;
        fresh_m = tx_wr;
      end
      if (tx_wr) begin hold_m = tx_data; fresh_m = 1; end
      #1;
      rxd = rxb[ppos / 8][bitof(ppos)];
      fsync = (fs_per > 0) && ($urandom % fs_per == 0);
      tx_wr = ($urandom % 100) < wr_pct;
      tx_data = 8'($urandom);
      rx_rd = ($urandom % 100) < rd_pct;
      @(negedge clk);
      #1;
      chk(txd_oe == exp_oe, exp_oe ? "R2 R3 txd_oe" : "R2 R4 txd_oe", txd_oe, exp_oe);
      if (exp_oe)
        chk(txd == cur_tx[bitof(ppos)], (ppos / 8 == 0) ? "R1 R3 txd" : "R3 txd",
            txd, cur_tx[bitof(ppos)]);
      chk(tx_underrun == exp_und, "R7 tx_underrun", tx_underrun, exp_und);
      chk(rx_valid == exp_rxv, "R5 rx_valid", rx_valid, exp_rxv);
      chk(rx_data == last_rxd, rx_also_tx ? "R8 rx_data" : "R5 rx_data", rx_data, last_rxd);
      chk(rx_overrun == exp_ovr, "R6 rx_overrun", rx_overrun, exp_ovr);
    end
  endtask

  initial begin
    void'($urandom(32'd4925));
    for (int s = 0; s < 64; s++) rxb[s] = 8'($urandom);
    // full service, free-running frame, disjoint slots
    do_reset(3, 4'b0011, {5'd0, 5'd0, 5'd2, 5'd0}, 4'b0011, {5'd0, 5'd0, 5'd3, 5'd1});
    run(1500, 0, 100, 100);
    // largest frame, random sync, rx and tx overlap on one offset (R8)
    do_reset(31, 4'b1111, {5'd31, 5'd17, 5'd9, 5'd4}, 4'b1111, {5'd0, 5'd30, 5'd12, 5'd4});
    run(4000, 300, 50, 50);
    // one slot per half-frame, starved writes and reads
    do_reset(0, 4'b1111, 20'd0, 4'b1111, 20'd0);
    run(1500, 0, 8, 5);
    // offsets beyond the half-frame and disabled selectors on offset 0
    do_reset(7, 4'b1110, {5'd31, 5'd20, 5'd8, 5'd0}, 4'b1110, {5'd9, 5'd15, 5'd31, 5'd0});
    run(1500, 70, 50, 50);
    // random configurations with mid-slot syncs
    for (int k = 0; k < 5; k++) begin
      int hm;
      hm = $urandom % 32;
      do_reset(hm, 4'($urandom), 20'($urandom) & {4{5'(hm)}},
               4'($urandom), 20'($urandom) & {4{5'(hm)}});
      run(2000, 20 + $urandom % 200, $urandom % 100, $urandom % 100);
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule